// File: doc/BRIEF.md
# Serial ADC capture controller

This block drives a 14-bit serial-output sampling converter from the master side. From the system clock it makes a free-running serial clock and, once per frame, a one-serial-period conversion-start pulse. In the frame that follows each pulse it samples the converter's data line on falling serial-clock edges and keeps the 14 bits that carry the result. The result is right-justified in a 16-bit-time window: the first two bit times are dropped, and so is any extra bit time the frame is padded with.

Each result goes into a two-bank ping-pong sample memory. Results fill one bank entry by entry. When the last entry is written, a one-cycle ready pulse reports the index of the full bank, and writing moves on to the other bank with no gap. The consumer reads a bank through a synchronous read port. It then returns an acknowledge for that bank index.

The converter cannot be stalled, so there is no back-pressure on capture. If a bank is still unacknowledged when writing has to come back to it, a sticky overrun flag is raised. Writing goes on regardless.

Top module: `adc_frame_capture`

## Requirements
- R1: During and after a synchronous reset, `sclk_o` and `conv_o` are low, `bank_rdy_o` and `overrun_o` are low, and the write pointer is at bank 0, entry 0. The first bank reported after reset is bank 0, and its entry 0 holds the first sample taken after reset.
- R2: `sclk_o` has a period of `CLK_DIV` system cycles. It is high for `CLK_DIV/2` cycles, starting with the cycle after its rising transition.
- R3: `conv_o` rises together with a falling `sclk_o` transition, stays high for exactly `CLK_DIV` system cycles, and repeats every `FRAME_CLKS * CLK_DIV` cycles. The first pulse comes after exactly `FRAME_CLKS` rising serial-clock edges following reset.
- R4: The bit times of a frame are numbered 0 from the first rising serial edge after the pulse. Data is sampled on the falling edge of bit times 2 to 15, MSB first, and the value on `sdo_i` in every other bit time has no effect on the stored sample.
- R5: Successive samples are written to successive entries of the current bank, and each stored value is the 14 sampled bits.
- R6: After the last entry (`BANK_DEPTH-1`) of a bank is written, `bank_rdy_o` is high for exactly one cycle with `bank_id_o` set to that bank. Writing then continues at entry 0 of the other bank, so the bank indices reported alternate 0, 1, 0, ...
- R7: `overrun_o` is set when a bank completes while the other bank, which is about to be refilled, is still unacknowledged. An `ack_i` pulse with `ack_bank_i` clears that bank's pending state. Once set, `overrun_o` stays high until reset.
- R8: `rd_data_o` shows the entry at `rd_addr_i` one cycle after the address is applied. The MSB of `rd_addr_i` selects the bank and the lower bits select the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdo_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Conversion-start pulse |
| rd_addr_i | input | $clog2(BANK_DEPTH)+1 | Read address {bank, entry} |
| rd_data_o | output | 14 | Read data, one cycle latency |
| bank_rdy_o | output | 1 | One-cycle pulse: a bank is full |
| bank_id_o | output | 1 | Index of the bank just completed |
| ack_i | input | 1 | Consumer has finished with a bank |
| ack_bank_i | input | 1 | Bank index for `ack_i` |
| overrun_o | output | 1 | Sticky: an unacknowledged bank was reused |

## Verification
A behavioural converter model answers each conversion pulse with a 14-bit code. It drives junk of its own choosing in the two leading bit times and inverted junk in the trailing padding bit times. The bench uses twelve codes: all zeros, all ones, alternating patterns, a lone MSB, a lone LSB, and mixed values. Between them, these codes show whether the bit window is shifted by one place, whether the order is reversed, or whether padding bits leak into a result. Three full banks check the alternating bank order and the continuous entry addressing. One bank is deliberately left unacknowledged to show that overrun is raised only on actual reuse, and that it then stays set. A reset in the middle of a run confirms that the pointer and the pulse timing start over.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int SAMPLE_W  = 14;
  localparam int LEAD_BITS = 2;

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    logic    valid;
    sample_t data;
  } sample_wr_t;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_CLKS = 16,
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int BW = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          sclk,
  output logic          conv,
  output logic          fall_evt,
  output logic          live,
  output logic [BW-1:0] bit_idx
);
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] div_cnt;
  logic          rise_evt;
  logic          armed;

  assign rise_evt = (div_cnt == CW'(CLK_DIV - 1));
  assign fall_evt = (div_cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
      conv    <= 1'b0;
      live    <= 1'b0;
      armed   <= 1'b0;
      bit_idx <= BW'(FRAME_CLKS - 1);
    end else begin
      div_cnt <= rise_evt ? '0 : div_cnt + 1'b1;
      if (rise_evt) begin
        sclk    <= 1'b1;
        armed   <= 1'b1;
        bit_idx <= (bit_idx == BW'(FRAME_CLKS - 1)) ? '0 : bit_idx + 1'b1;
      end
      if (fall_evt) begin
        sclk <= 1'b0;
        if (armed && bit_idx == BW'(FRAME_CLKS - 1)) begin
          conv <= 1'b1;
          live <= 1'b1;
        end else begin
          conv <= 1'b0;
        end
      end
    end
  end

  // R1: reset idles both outputs
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!sclk && !conv));

  // R3: pulse starts on a falling serial edge at the end of a frame
  p_conv_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv) |-> ($fell(sclk) && bit_idx == BW'(FRAME_CLKS - 1)));

  // R3: pulse lasts longer than one system cycle
  p_conv_held_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv) |=> conv);
endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx
  import adc_cap_pkg::*;
#(
  parameter int FRAME_CLKS = 16,
  localparam int BW = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sdo,
  input  logic          fall_evt,
  input  logic          live,
  input  logic [BW-1:0] bit_idx,
  output sample_wr_t    wr
);
  localparam int FIRST = LEAD_BITS;
  localparam int LAST  = LEAD_BITS + SAMPLE_W - 1;

  logic [SAMPLE_W-2:0] shift_q;
  logic                in_window;
  logic                at_last;

  assign in_window = live && fall_evt &&
                     (bit_idx >= BW'(FIRST)) && (bit_idx <= BW'(LAST));
  assign at_last   = (bit_idx == BW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      wr.valid <= 1'b0;
      wr.data  <= '0;
    end else begin
      wr.valid <= in_window && at_last;
      if (in_window) begin
        shift_q <= {shift_q[SAMPLE_W-3:0], sdo};
        if (at_last) wr.data <= {shift_q, sdo};
      end
    end
  end

  // R5: at most one write per frame
  p_single_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr.valid |=> !wr.valid);

  // R4: a write follows only the last bit time of the window
  p_write_at_window_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr.valid) |-> ($past(bit_idx) == BW'(LAST)));
endmodule

// File: rtl/adc_pingpong_buf.sv
module adc_pingpong_buf
  import adc_cap_pkg::*;
#(
  parameter int BANK_DEPTH = 1024,
  localparam int AW = $clog2(BANK_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  sample_wr_t    wr,
  input  logic [AW:0]   rd_addr,
  output sample_t       rd_data,
  input  logic          ack,
  input  logic          ack_bank,
  output logic          bank_rdy,
  output logic          bank_id,
  output logic          overrun
);
  sample_t     mem [2*BANK_DEPTH];
  logic [AW-1:0] wr_idx;
  logic        bank_sel;
  logic        pending_q [2];
  logic        bank_done;
  logic        other_acked;

  assign bank_done   = wr.valid && (wr_idx == AW'(BANK_DEPTH - 1));
  assign other_acked = ack && (ack_bank == ~bank_sel);

  always_ff @(posedge clk) begin
    if (wr.valid) mem[{bank_sel, wr_idx}] <= wr.data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      bank_sel <= 1'b0;
      bank_rdy <= 1'b0;
      bank_id  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      bank_rdy <= 1'b0;
      if (wr.valid) wr_idx <= bank_done ? '0 : wr_idx + 1'b1;
      if (bank_done) begin
        bank_sel <= ~bank_sel;
        bank_rdy <= 1'b1;
        bank_id  <= bank_sel;
        if (pending_q[~bank_sel] && !other_acked) overrun <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        pending_q[b] <= 1'b0;
      else if (bank_done && bank_sel == 1'(b))
        pending_q[b] <= 1'b1;
      else if (ack && ack_bank == 1'(b))
        pending_q[b] <= 1'b0;
    end
  end

  // R1: pointer and flags start from bank 0, entry 0
  p_ptr_home_r1: assert property (@(posedge clk)
    rst |=> (wr_idx == '0 && !bank_sel && !overrun && !bank_rdy));

  // R6: ready is a single-cycle pulse
  p_rdy_single_r6: assert property (@(posedge clk) disable iff (rst)
    bank_rdy |=> !bank_rdy);

  // R6: the reported bank is not the one now being written
  p_rdy_other_bank_r6: assert property (@(posedge clk) disable iff (rst)
    bank_rdy |-> (bank_id != bank_sel && wr_idx == '0));

  // R7: overrun is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture
  import adc_cap_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_CLKS = 16,
  parameter int BANK_DEPTH = 1024
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sdo_i,
  output logic                          sclk_o,
  output logic                          conv_o,
  input  logic [$clog2(BANK_DEPTH):0]   rd_addr_i,
  output logic [13:0]                   rd_data_o,
  output logic                          bank_rdy_o,
  output logic                          bank_id_o,
  input  logic                          ack_i,
  input  logic                          ack_bank_i,
  output logic                          overrun_o
);
  localparam int BW = $clog2(FRAME_CLKS);

  logic          fall_evt;
  logic          live;
  logic [BW-1:0] bit_idx;
  sample_wr_t    wr;
  sample_t       rd_data;

  adc_sclk_gen #(.CLK_DIV(CLK_DIV), .FRAME_CLKS(FRAME_CLKS)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk_o),
    .conv     (conv_o),
    .fall_evt (fall_evt),
    .live     (live),
    .bit_idx  (bit_idx)
  );

  adc_shift_rx #(.FRAME_CLKS(FRAME_CLKS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .sdo      (sdo_i),
    .fall_evt (fall_evt),
    .live     (live),
    .bit_idx  (bit_idx),
    .wr       (wr)
  );

  adc_pingpong_buf #(.BANK_DEPTH(BANK_DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data),
    .ack      (ack_i),
    .ack_bank (ack_bank_i),
    .bank_rdy (bank_rdy_o),
    .bank_id  (bank_id_o),
    .overrun  (overrun_o)
  );

  assign rd_data_o = rd_data;
endmodule

// File: tb/adc_frame_capture_tb.sv
module adc_frame_capture_tb_top;
  localparam int DIV   = 4;
  localparam int FRAME = 18;
  localparam int DEPTH = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int NVEC  = 12;

  // [15:14] junk for the two leading bit times, [13:0] converter code
  localparam logic [15:0] VEC [NVEC] = '{
    16'hC000, 16'h3FFF, 16'hAAAA, 16'h5555, 16'hE000, 16'h0001,
    16'h5234, 16'h8F0F, 16'hFC3C, 16'h2001, 16'h9FFE, 16'h4ABC
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdo = 1'b1;
  logic [AW:0] rd_addr = '0;
  logic [13:0] rd_data;
  logic sclk, conv, bank_rdy, bank_id, overrun;
  logic ack = 1'b0;
  logic ack_bank = 1'b0;

  always #10 clk = ~clk;

  adc_frame_capture #(.CLK_DIV(DIV), .FRAME_CLKS(FRAME), .BANK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .sdo_i(sdo), .sclk_o(sclk), .conv_o(conv),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .bank_rdy_o(bank_rdy),
    .bank_id_o(bank_id), .ack_i(ack), .ack_bank_i(ack_bank), .overrun_o(overrun)
  );

  // behavioural converter
  int          frame_no = 0;
  int          edge_no  = 0;
  logic [15:0] cur      = 16'hFFFF;

  always @(posedge conv) begin
    cur      = VEC[frame_no % NVEC];
    frame_no = frame_no + 1;
    edge_no  = 0;
  end

  always @(posedge sclk) begin
    edge_no = edge_no + 1;
    if (edge_no == 1)                      sdo = cur[15];
    else if (edge_no == 2)                 sdo = cur[14];
    else if (edge_no >= 3 && edge_no <= 16) sdo = cur[13 - (edge_no - 3)];
    else                                   sdo = ~cur[0];
  end

  // waveform monitor for timing requirements
  logic sc_prev = 1'b0, cv_prev = 1'b0, seen_conv = 1'b0;
  int sc_cyc = 0, per_last = 0, hi_run = 0, hi_last = 0;
  int cv_run = 0, cv_last = 0, cv_cyc = 0, gap_last = 0, rises_before = 0;

  always @(negedge clk) begin
    if (rst) begin
      sc_prev = 1'b0; cv_prev = 1'b0; seen_conv = 1'b0;
      sc_cyc = 0; hi_run = 0; cv_run = 0; cv_cyc = 0; rises_before = 0;
    end else begin
      sc_cyc = sc_cyc + 1;
      cv_cyc = cv_cyc + 1;
      if (sclk && !sc_prev) begin
        per_last = sc_cyc; sc_cyc = 0;
        if (!seen_conv) rises_before = rises_before + 1;
      end
      if (sclk) hi_run = hi_run + 1;
      else if (sc_prev) begin hi_last = hi_run; hi_run = 0; end
      if (conv && !cv_prev) begin gap_last = cv_cyc; cv_cyc = 0; seen_conv = 1'b1; end
      if (conv) cv_run = cv_run + 1;
      else if (cv_prev) begin cv_last = cv_run; cv_run = 0; end
      sc_prev = sclk;
      cv_prev = conv;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rdy(input string req);
    int t = 0;
    do begin @(negedge clk); t = t + 1; end while (!bank_rdy && t < 3000);
    chk(bank_rdy, req, 0, 1);
  endtask

  task automatic ack_bank_pulse(input logic b);
    @(negedge clk); ack = 1'b1; ack_bank = b;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    chk(!sclk && !conv, "R1", {sclk, conv}, 0);
    chk(!bank_rdy && !overrun, "R1", {bank_rdy, overrun}, 0);
    rst = 1'b0;

    // vector table walk: R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      if (i % DEPTH == 0) begin
        wait_rdy("R6");
        chk(bank_id == 1'((i / DEPTH) % 2), "R6", bank_id, (i / DEPTH) % 2);
      end
      @(negedge clk);
      if (i % DEPTH == 0) chk(!bank_rdy, "R6", bank_rdy, 0);
      rd_addr = {1'((i / DEPTH) % 2), AW'(i % DEPTH)};
      @(negedge clk);
      chk(rd_data == VEC[i][13:0], "R4 R5 R8", rd_data, VEC[i][13:0]);
      if (i % DEPTH == DEPTH - 1) ack_bank_pulse(1'((i / DEPTH) % 2));
    end

    // serial clock and pulse timing, R2 R3
    chk(per_last == DIV, "R2", per_last, DIV);
    chk(hi_last == DIV / 2, "R2", hi_last, DIV / 2);
    chk(cv_last == DIV, "R3", cv_last, DIV);
    chk(gap_last == FRAME * DIV, "R3", gap_last, FRAME * DIV);
    chk(rises_before == FRAME, "R3", rises_before, FRAME);
    chk(!overrun, "R7", overrun, 0);

    // overrun, R7: leave bank 1 unacknowledged
    wait_rdy("R7");
    chk(bank_id == 1'b1 && !overrun, "R7", {bank_id, overrun}, 2);
    wait_rdy("R7");
    chk(bank_id == 1'b0 && overrun, "R7", {bank_id, overrun}, 1);
    ack_bank_pulse(1'b1);
    ack_bank_pulse(1'b0);
    repeat (5) @(negedge clk);
    chk(overrun, "R7", overrun, 1);

    // mid-run reset, R1
    rst = 1'b1; frame_no = 0;
    repeat (2) @(negedge clk);
    chk(!sclk && !conv && !overrun, "R1", {sclk, conv, overrun}, 0);
    rst = 1'b0;
    wait_rdy("R1");
    chk(bank_id == 1'b0, "R1", bank_id, 0);
    @(negedge clk); rd_addr = '0;
    @(negedge clk);
    chk(rd_data == VEC[0][13:0], "R1", rd_data, VEC[0][13:0]);
    chk(rises_before == FRAME, "R3", rises_before, FRAME);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule